// File: doc/BRIEF.md
# Chunky-to-Planar Write-Through Converter

This block takes packed pixel data (chunky format) from a processor and regroups it into bitplane words, so software does not have to shuffle bits itself. The processor talks to it through a small register port. A batch of chunky words is written into one data register. When the batch is complete, the block turns it into one 32-bit word per bitplane. Each batch covers 32 pixels in every mode.

In read-back mode the planar words are fetched one at a time by reading the same data register. In write-through mode they are sent out on a simple memory-write master instead. Each word goes to the address held in that plane's pointer, and the pointer then advances by itself, so no address setup is needed between batches.

A two-entry batch buffer lets the processor load the next batch while the previous one is still being drained. When both entries are full, a further data write is held off through a ready signal rather than being lost.

Top module: `c2p_writethru`

## Requirements
- R1: Control register (address 1) bits [1:0] select the depth: 01 gives 2 planes, 10 gives 4 planes, 00 and 11 give 8 planes. A batch is exactly as many writes to the data register (address 0) as there are planes.
- R2: A write holds 32/D pixels of D bits each, with the leftmost pixel in the most significant bits. Across a batch the pixels are numbered k = 0..31, and bit n of pixel k becomes bit 31-k of plane n.
- R3: With control bit 2 at 0 (read-back mode), successive reads of address 0 return planes 0 up to D-1 of the oldest complete batch, in that order. Each word appears on reg_rdata in the cycle after the read is issued.
- R4: With control bit 2 at 1 (write-through mode), the planes go out on the memory port in order 0 up to D-1. Each goes to the pointer of its plane (register address 8+n). That pointer grows by 4 after each accepted write, and planes D and above are neither written nor advanced.
- R5: Once mem_wr_valid is raised, it stays high with unchanged address and data until mem_wr_ready accepts the word.
- R6: Up to two complete batches are buffered. When both entries are full, reg_ready is low and a data write is not taken until space frees. Every stalled word is later converted, and none is lost.
- R7: In read-back mode with no complete batch buffered, a read of address 0 returns the last planar word delivered and sets err_flag (also control bit 4). The flag stays set until a control write with bit 3 at 1.
- R8: Any control write discards the words of a partially written batch, so the next data write starts a new batch.
- R9: Synchronous reset empties the buffer and clears the write counter, the pointers, the control register, err_flag and reg_rdata.
- R10: In write-through mode a read of address 0 returns the last planar word delivered, consumes nothing and leaves err_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address: 0 data, 1 control, 8..15 plane pointers |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Low while a data write cannot be taken |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| err_flag | output | 1 | Sticky premature-read flag |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | 32 | Byte address of the planar word |
| mem_wr_data | output | 32 | Planar word |

## Verification
The assertion that holds the memory request stable assumes that no register write lands while a write-through word is waiting. The stimulus never changes the control or pointer registers while planar words are still outstanding. The buffer assertions assume that pushes only happen when reg_ready is high, and the stimulus always samples reg_ready before the clock edge. The sink's ready is driven as always-low, always-high, and alternating, so that both the hold case and the back-to-back case occur.

// File: rtl/c2p_pkg.sv
`timescale 1ns/1ps
package c2p_pkg;
  localparam int PIX_W       = 32;
  localparam int MAX_PLANES  = 8;
  localparam int PLANE_IDX_W = $clog2(MAX_PLANES);
  localparam int CNT_W       = PLANE_IDX_W + 1;
  localparam int REG_AW      = PLANE_IDX_W + 1;
  localparam int BATCH_W     = MAX_PLANES * PIX_W + CNT_W;

  typedef logic [MAX_PLANES-1:0][PIX_W-1:0] plane_set_t;

  typedef enum logic [1:0] {
    DEPTH_FULL_A = 2'b00,
    DEPTH_TWO    = 2'b01,
    DEPTH_FOUR   = 2'b10,
    DEPTH_FULL_B = 2'b11
  } depth_e;

  function automatic logic [CNT_W-1:0] planes_of(logic [1:0] code);
    case (code)
      DEPTH_TWO:  return CNT_W'(2);
      DEPTH_FOUR: return CNT_W'(4);
      default:    return CNT_W'(MAX_PLANES);
    endcase
  endfunction
endpackage

// File: rtl/c2p_shuffle.sv
`timescale 1ns/1ps
// Pure wiring: regroups a batch of chunky words at a fixed depth.
module c2p_shuffle
  import c2p_pkg::*;
#(
  parameter int BPP = 8
) (
  input  plane_set_t chunky,
  output plane_set_t planar
);
  localparam int PPW = PIX_W / BPP;  // pixels per chunky word

  for (genvar n = 0; n < MAX_PLANES; n++) begin : g_plane
    for (genvar k = 0; k < PIX_W; k++) begin : g_pix
      if (n < BPP) begin : g_on
        assign planar[n][PIX_W-1-k] = chunky[k/PPW][PIX_W - ((k%PPW) + 1)*BPP + n];
      end else begin : g_off
        assign planar[n][PIX_W-1-k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/c2p_batch_fifo.sv
`timescale 1ns/1ps
module c2p_batch_fifo #(
  parameter int W     = 260,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // R6: a batch is never pushed into a full buffer nor popped from an empty one
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/c2p_writethru.sv
`timescale 1ns/1ps
module c2p_writethru
  import c2p_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_DEPTH = 2,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [PIX_W-1:0]  reg_wdata,
  output logic              reg_ready,
  output logic [PIX_W-1:0]  reg_rdata,
  output logic              err_flag,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [PIX_W-1:0]  mem_wr_data
);
  localparam logic [REG_AW-1:0] A_DATA = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(1);
  localparam int                N_VAR  = PLANE_IDX_W;  // depths 2,4,8

  logic [1:0]             depth_q;
  logic                   wt_q, err_q;
  logic [PLANE_IDX_W-1:0] wcnt_q, pidx_q;
  plane_set_t             chunk_q, chunk_nx, conv_sel, head_set;
  plane_set_t             conv [N_VAR];
  logic [ADDR_W-1:0]      ptr_q [MAX_PLANES];
  logic [PIX_W-1:0]       last_q, head_word;
  logic [CNT_W-1:0]       cur_planes, head_planes;
  logic [BATCH_W-1:0]     head_raw;
  logic fifo_full, fifo_empty, push, pop;
  logic is_data, is_ctrl, is_ptr, data_wr, wt_fire, rb_fire, step, last_plane;

  assign is_data    = (reg_addr == A_DATA);
  assign is_ctrl    = (reg_addr == A_CTRL);
  assign is_ptr     = reg_addr[REG_AW-1];
  assign cur_planes = planes_of(depth_q);
  assign data_wr    = reg_wr && is_data && !fifo_full;
  assign push       = data_wr && (CNT_W'(wcnt_q) == cur_planes - 1'b1);
  assign reg_ready  = !fifo_full;

  // ---------------- collect side ----------------
  always_comb begin
    chunk_nx         = chunk_q;
    chunk_nx[wcnt_q] = reg_wdata;
  end

  for (genvar g = 0; g < N_VAR; g++) begin : g_conv
    c2p_shuffle #(.BPP(2 << g)) u_shuf (.chunky(chunk_nx), .planar(conv[g]));
  end

  always_comb begin
    case (depth_q)
      DEPTH_TWO:  conv_sel = conv[0];
      DEPTH_FOUR: conv_sel = conv[1];
      default:    conv_sel = conv[N_VAR-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (data_wr) chunk_q <= chunk_nx;
  end

  c2p_batch_fifo #(.W(BATCH_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst(rst), .push(push), .push_data({cur_planes, conv_sel}),
    .pop(pop), .head(head_raw), .full(fifo_full), .empty(fifo_empty)
  );

  // ---------------- drain side ----------------
  assign head_set    = head_raw[MAX_PLANES*PIX_W-1:0];
  assign head_planes = head_raw[BATCH_W-1 -: CNT_W];
  assign head_word   = head_set[pidx_q];
  assign wt_fire     = wt_q && !fifo_empty && mem_wr_ready;
  assign rb_fire     = reg_rd && is_data && !wt_q && !fifo_empty;
  assign step        = wt_fire || rb_fire;
  assign last_plane  = (CNT_W'(pidx_q) == head_planes - 1'b1);
  assign pop         = step && last_plane;

  assign mem_wr_valid = wt_q && !fifo_empty;
  assign mem_wr_addr  = ptr_q[pidx_q];
  assign mem_wr_data  = head_word;
  assign err_flag     = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q   <= '0;
      wt_q      <= 1'b0;
      err_q     <= 1'b0;
      wcnt_q    <= '0;
      pidx_q    <= '0;
      last_q    <= '0;
      reg_rdata <= '0;
      for (int i = 0; i < MAX_PLANES; i++) ptr_q[i] <= '0;
    end else begin
      if (data_wr) wcnt_q <= push ? '0 : wcnt_q + 1'b1;
      if (reg_wr && is_ctrl) begin
        depth_q <= reg_wdata[1:0];
        wt_q    <= reg_wdata[2];
        wcnt_q  <= '0;
        if (reg_wdata[3]) err_q <= 1'b0;
      end
      if (step) begin
        pidx_q <= last_plane ? '0 : pidx_q + 1'b1;
        last_q <= head_word;
      end
      if (wt_fire) ptr_q[pidx_q] <= ptr_q[pidx_q] + ADDR_W'(ADDR_STEP);
      if (reg_wr && is_ptr) ptr_q[reg_addr[PLANE_IDX_W-1:0]] <= ADDR_W'(reg_wdata);
      if (reg_rd) begin
        if (is_data) begin
          reg_rdata <= rb_fire ? head_word : last_q;
          if (!wt_q && fifo_empty) err_q <= 1'b1;
        end else if (is_ctrl) begin
          reg_rdata <= PIX_W'({err_q, 1'b0, wt_q, depth_q});
        end else if (is_ptr) begin
          reg_rdata <= PIX_W'(ptr_q[reg_addr[PLANE_IDX_W-1:0]]);
        end else begin
          reg_rdata <= '0;
        end
      end
    end
  end

  // R5: a pending memory request is held until accepted
  a_r5_hold_request: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_ready && !reg_wr |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
  // R7: the error flag only drops on an explicit clear
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q && !(reg_wr && is_ctrl && reg_wdata[3]) |=> err_q);
  // R6: a refused data write leaves the batch position untouched
  a_r6_stall_no_take: assert property (@(posedge clk) disable iff (rst)
    reg_wr && is_data && !reg_ready |=> $stable(wcnt_q));
  // R4: the drain position never passes the plane count of the head batch
  a_r4_plane_range: assert property (@(posedge clk) disable iff (rst)
    !fifo_empty |-> CNT_W'(pidx_q) < head_planes);
endmodule

// File: tb/sim_c2p_writethru.sv
`timescale 1ns/1ps
module sim_c2p_writethru;
  import c2p_pkg::*;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              reg_ready, err_flag, mem_wr_valid;
  logic              mem_wr_ready = 1'b0;
  logic [31:0]       mem_wr_addr, mem_wr_data;

  c2p_writethru u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .err_flag(err_flag), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int checks = 0, fails = 0, cyc = 0, rdy_mode = 0;

  // reference model state
  logic [31:0] exp_addr_q[$], exp_data_q[$], rb_q[$];
  logic [31:0] mptr [8];
  logic [31:0] chunk_buf [8];
  logic [31:0] last_mem = '0;
  int  ncol = 0, depth_model = 8;
  bit  wt_model = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    exp_addr_q.delete(); exp_data_q.delete(); rb_q.delete();
    for (int i = 0; i < 8; i++) mptr[i] = '0;
    ncol = 0; depth_model = 8; wt_model = 0;
  endtask

  function automatic void model_batch();
    int ppw = 32 / depth_model;
    logic [31:0] pl [8];
    for (int n = 0; n < 8; n++) pl[n] = '0;
    for (int k = 0; k < 32; k++) begin
      int w = k / ppw;
      int s = k % ppw;
      logic [7:0] pix;
      pix = 8'((chunk_buf[w] >> (32 - (s + 1) * depth_model)) & ((1 << depth_model) - 1));
      for (int n = 0; n < depth_model; n++) pl[n][31-k] = pix[n];
    end
    for (int n = 0; n < depth_model; n++) begin
      if (wt_model) begin
        exp_addr_q.push_back(mptr[n]);
        exp_data_q.push_back(pl[n]);
        mptr[n] = mptr[n] + 32'd4;
      end else begin
        rb_q.push_back(pl[n]);
      end
    end
  endfunction

  task automatic reg_write(logic [REG_AW-1:0] a, logic [31:0] d, output int stalls);
    bit acc;
    stalls = 0;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    do begin
      #1;
      acc = reg_ready || (a != 0);
      @(posedge clk);
      if (acc) begin
        if (a == 0) begin
          chunk_buf[ncol] = d; ncol++;
          if (ncol == depth_model) begin model_batch(); ncol = 0; end
        end else if (a == 1) begin
          depth_model = (d[1:0] == 2'b01) ? 2 : (d[1:0] == 2'b10) ? 4 : 8;
          wt_model = d[2]; ncol = 0;
        end else if (a[3]) begin
          mptr[a[2:0]] = d;
        end
      end else begin
        stalls++;
        @(negedge clk);
      end
    end while (!acc);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(logic [REG_AW-1:0] a, logic [31:0] d);
    int s;
    reg_write(a, d, s);
  endtask

  task automatic rd(logic [REG_AW-1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] pat(int seed, int i);
    return (32'h9E37_79B9 * (seed * 8 + i + 1)) ^ (32'h0101_0101 * seed) ^ 32'hA5C3_0F96;
  endfunction

  task automatic send_batch(int seed, int n);
    for (int i = 0; i < n; i++) wr(0, pat(seed, i));
  endtask

  task automatic read_all(int n, string req);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      rd(0, v);
      if (rb_q.size() == 0) chk(req, v, 32'hDEAD_BEEF);
      else chk(req, v, rb_q.pop_front());
    end
  endtask

  task automatic wait_drain();
    int n = 0;
    while (exp_addr_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  // sink ready: 0 never, 1 always, 2 alternating
  always @(posedge clk) begin
    cyc++;
    mem_wr_ready <= (rdy_mode == 1) || (rdy_mode == 2 && (cyc % 2 == 0));
  end

  // per-cycle comparison of the memory port against the model
  logic        pv_valid = 1'b0, pv_ready = 1'b0;
  logic [31:0] pv_addr = '0, pv_data = '0;
  always @(negedge clk) begin
    if (rst) begin
      pv_valid = 1'b0; pv_ready = 1'b0;
    end else begin
      if (pv_valid && !pv_ready) begin
        checks++;
        if (!(mem_wr_valid && mem_wr_addr == pv_addr && mem_wr_data == pv_data)) begin
          fails++;
          $display("FAIL R5 actual=%b/%h/%h expected=1/%h/%h",
                   mem_wr_valid, mem_wr_addr, mem_wr_data, pv_addr, pv_data);
        end
      end
      if (mem_wr_valid && mem_wr_ready) begin
        if (exp_addr_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4 unexpected write actual=%h expected=none", mem_wr_addr);
        end else begin
          chk("R4 address", mem_wr_addr, exp_addr_q.pop_front());
          chk("R2 planar data", mem_wr_data, exp_data_q.pop_front());
        end
        last_mem = mem_wr_data;
      end
      pv_valid = mem_wr_valid; pv_ready = mem_wr_ready;
      pv_addr = mem_wr_addr;   pv_data = mem_wr_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=hang expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, lastv;
    int st;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk("R9 ready", 32'(reg_ready), 32'd1);
    chk("R9 valid", 32'(mem_wr_valid), 32'd0);
    chk("R9 err", 32'(err_flag), 32'd0);
    chk("R9 rdata", reg_rdata, 32'd0);
    rd(1, v); chk("R9 ctrl", v, 32'd0);
    rd(8, v); chk("R9 ptr0", v, 32'd0);

    // R2 directed: pixels 0x01,0x02,0x04,0x80 then zeros
    wr(0, 32'h0102_0480);
    for (int i = 1; i < 8; i++) wr(0, 32'h0);
    for (int n = 0; n < 8; n++) begin
      logic [31:0] e;
      e = (n == 0) ? 32'h8000_0000 : (n == 1) ? 32'h4000_0000 :
          (n == 2) ? 32'h2000_0000 : (n == 7) ? 32'h1000_0000 : 32'h0;
      rd(0, v); chk("R2 bit mapping", v, e);
      void'(rb_q.pop_front());
    end

    // R3 read-back at 8 planes
    send_batch(1, 8); read_all(8, "R3 readback 8");
    // R1 4 planes, then 2 planes
    wr(1, 32'h2); send_batch(2, 4); read_all(4, "R1 depth 4");
    wr(1, 32'h1); send_batch(3, 2);
    rd(0, v); chk("R1 depth 2 p0", v, rb_q.pop_front());
    rd(0, v); chk("R1 depth 2 p1", v, rb_q.pop_front());
    lastv = v;

    // R7 premature read
    rd(0, v); chk("R7 last word", v, lastv);
    chk("R7 err set", 32'(err_flag), 32'd1);
    wr(1, 32'h1);
    chk("R7 err sticky", 32'(err_flag), 32'd1);
    rd(1, v); chk("R7 ctrl bit4", v, 32'h11);
    wr(1, 32'h8);
    chk("R7 err cleared", 32'(err_flag), 32'd0);

    // R8 control write drops partial batch
    send_batch(4, 3); wr(1, 32'h0);
    send_batch(5, 8); read_all(8, "R8 restart");

    // R6 and R4: write-through with a blocked sink
    for (int n = 0; n < 8; n++) wr(REG_AW'(8 + n), 32'h1000 * (n + 1));
    rdy_mode = 0;
    wr(1, 32'h4);
    send_batch(6, 8); send_batch(7, 8);
    #1 chk("R6 ready low when full", 32'(reg_ready), 32'd0);
    fork
      begin repeat (20) @(negedge clk); rdy_mode = 1; end
      reg_write(0, pat(8, 0), st);
    join
    checks++;
    if (st < 15) begin
      fails++;
      $display("FAIL R6 stall cycles actual=%0d expected>=15", st);
    end
    for (int i = 1; i < 8; i++) wr(0, pat(8, i));
    wait_drain();
    chk("R6 all drained", 32'(exp_addr_q.size()), 32'd0);
    for (int n = 0; n < 8; n++) begin
      rd(REG_AW'(8 + n), v); chk("R4 pointer advance", v, mptr[n]);
    end

    // R4 at 4 planes with alternating sink (R5 exercised by the monitor)
    rdy_mode = 2;
    wr(1, 32'h6);
    send_batch(9, 4); send_batch(10, 4);
    wait_drain();
    chk("R4 idle after batch", 32'(mem_wr_valid), 32'd0);
    rd(12, v); chk("R4 plane4 untouched", v, mptr[4]);
    rd(9, v);  chk("R4 plane1 advanced", v, mptr[1]);

    // R10 read in write-through mode
    rd(0, v); chk("R10 last word", v, last_mem);
    chk("R10 no error", 32'(err_flag), 32'd0);

    // R9 reset mid-batch
    wr(1, 32'h0);
    send_batch(11, 3);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R9 ready after reset", 32'(reg_ready), 32'd1);
    rd(11, v); chk("R9 ptr3 cleared", v, 32'd0);
    rd(1, v);  chk("R9 ctrl cleared", v, 32'd0);
    send_batch(12, 8); read_all(8, "R9 counter cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule